// File: doc/BRIEF.md
# Compare Flag Generator and Branch Condition Evaluator

This block produces the status flags of compare and test operations and decides conditional branches and counted loops from them. A compare subtracts the second operand from the first at 16-bit or 32-bit width and keeps only the flags. A test ANDs the operands and keeps only the flags. Both can take the second operand as a short immediate that is sign-extended first. The flags stay in a register until the next compare or test.

A branch operation reads the stored flags and a 4-bit condition code, then reports whether the branch is taken. A loop operation decrements a counter value given with the operation and returns the new count. It reports taken while the new count is nonzero, optionally also requiring the zero flag set or clear. Neither a branch nor a loop touches the flags. Each accepted operation gives its result one cycle later, marked by `done_o`. Updating the program counter and fetching instructions are left to the surrounding pipeline.

Top module: `flagcond_top`

## Requirements
- R1: After a synchronous reset, `done_o`, `take_o`, all five flags and `cnt_o` are zero.
- R2: Compare (`op_sel`=0) forms first minus second at the selected width (`wide`=1: DATA_W bits, `wide`=0: the low NARROW_W bits, higher operand bits ignored). ZF is set when that result is zero, SF is its top bit, and CF is set when the first operand is below the second as unsigned.
- R3: On compare, OF is set exactly when the operand signs differ and the result sign differs from the first operand's sign.
- R4: With `imm_sext`=1, the second operand is replaced by its low IMM_W bits, sign-extended to the selected width, for both compare and test.
- R5: Test (`op_sel`=1) takes the AND of the operands at the selected width. It sets ZF and SF from that result and clears CF and OF.
- R6: PF is set when bits 7:0 of the compare or test result hold an even number of ones.
- R7: Branch (`op_sel`=2) signed codes use the stored flags: 1 equal (ZF), 2 not equal (!ZF), 3 greater (!ZF and SF==OF), 4 greater-or-equal (SF==OF), 5 less (SF!=OF), 6 less-or-equal (ZF or SF!=OF).
- R8: Branch unsigned codes: 7 above (!CF and !ZF), 8 above-or-equal (!CF), 9 below (CF), 10 below-or-equal (CF or ZF).
- R9: Branch codes 11 overflow (OF), 12 no overflow (!OF), 13 negative (SF), 14 non-negative (!SF), 0 always taken, 15 never taken.
- R10: Loop (`op_sel`=3) sets `cnt_o` to `cnt_in`-1 modulo 2^CNT_W. It is taken only when that value is nonzero and, for `cond[1:0]`=1, ZF=1 or, for `cond[1:0]`=2, ZF=0; codes 0 and 3 need no flag.
- R11: Branch and loop operations leave all five flags unchanged; `cnt_o` changes only on a loop.
- R12: `done_o` is high exactly in the cycle after a cycle with `in_valid` high, and `take_o` is low whenever `done_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| op_sel | input | 2 | 0 compare, 1 test, 2 branch, 3 loop |
| wide | input | 1 | 1: DATA_W-bit operands, 0: NARROW_W-bit |
| imm_sext | input | 1 | Second operand is a sign-extended IMM_W-bit immediate |
| opnd_a | input | DATA_W | First operand |
| opnd_b | input | DATA_W | Second operand |
| cond | input | 4 | Branch condition code, or loop variant in bits 1:0 |
| cnt_in | input | CNT_W | Loop counter before the decrement |
| done_o | output | 1 | Result of the previous cycle's operation is valid |
| take_o | output | 1 | Branch or loop is taken |
| zf_o | output | 1 | Zero flag |
| sf_o | output | 1 | Sign flag |
| cf_o | output | 1 | Carry (borrow) flag |
| of_o | output | 1 | Signed overflow flag |
| pf_o | output | 1 | Parity flag |
| cnt_o | output | CNT_W | Decremented loop counter |

## Verification
The bench builds the block with DATA_W=32, NARROW_W=16, IMM_W=8 and CNT_W=16. With both widths present, one operand pair can show a borrow or overflow at 16 bits that the 32-bit view hides. With an 8-bit immediate, sign extension into either width takes a single byte. With a 16-bit counter, the wrap from a zero count to all ones can be reached directly, next to the count-of-one loop exit.

// File: rtl/flagcond_pkg.sv
package flagcond_pkg;

    typedef enum logic [1:0] {
        OP_CMP    = 2'd0,
        OP_TEST   = 2'd1,
        OP_BRANCH = 2'd2,
        OP_LOOP   = 2'd3
    } op_e;

    typedef enum logic [3:0] {
        CC_ALWAYS = 4'd0,
        CC_EQ     = 4'd1,
        CC_NE     = 4'd2,
        CC_SGT    = 4'd3,
        CC_SGE    = 4'd4,
        CC_SLT    = 4'd5,
        CC_SLE    = 4'd6,
        CC_UGT    = 4'd7,
        CC_UGE    = 4'd8,
        CC_ULT    = 4'd9,
        CC_ULE    = 4'd10,
        CC_OV     = 4'd11,
        CC_NOV    = 4'd12,
        CC_NEG    = 4'd13,
        CC_POS    = 4'd14,
        CC_NEVER  = 4'd15
    } cc_e;

    typedef enum logic [1:0] {
        LP_PLAIN     = 2'd0,
        LP_WHILE_EQ  = 2'd1,
        LP_WHILE_NE  = 2'd2,
        LP_PLAIN_ALT = 2'd3
    } loop_e;

    typedef struct packed {
        logic zf;
        logic sf;
        logic cf;
        logic of;
        logic pf;
    } flags_t;

    localparam int PARITY_W = 8;

    function automatic logic even_ones(input logic [PARITY_W-1:0] v);
        return ~^v;
    endfunction

    function automatic logic cond_holds(input flags_t f, input cc_e cc);
        logic lt_signed;
        lt_signed = f.sf ^ f.of;
        case (cc)
            CC_ALWAYS: return 1'b1;
            CC_EQ:     return f.zf;
            CC_NE:     return !f.zf;
            CC_SGT:    return !f.zf && !lt_signed;
            CC_SGE:    return !lt_signed;
            CC_SLT:    return lt_signed;
            CC_SLE:    return f.zf || lt_signed;
            CC_UGT:    return !f.cf && !f.zf;
            CC_UGE:    return !f.cf;
            CC_ULT:    return f.cf;
            CC_ULE:    return f.cf || f.zf;
            CC_OV:     return f.of;
            CC_NOV:    return !f.of;
            CC_NEG:    return f.sf;
            CC_POS:    return !f.sf;
            default:   return 1'b0;
        endcase
    endfunction

    function automatic logic loop_gate(input flags_t f, input loop_e kind);
        case (kind)
            LP_WHILE_EQ: return f.zf;
            LP_WHILE_NE: return !f.zf;
            default:     return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/flag_gen.sv
module flag_gen
    import flagcond_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int NARROW_W = 16,
    parameter int IMM_W    = 8
) (
    input  logic              is_test,
    input  logic              wide,
    input  logic              imm_sext,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output flags_t            flags_o
);

    localparam int N_LANES = 2;

    initial begin
        if (NARROW_W <= IMM_W || DATA_W <= NARROW_W || NARROW_W < PARITY_W)
            $error("flag_gen: widths must satisfy PARITY_W <= NARROW_W, IMM_W < NARROW_W < DATA_W");
    end

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        localparam int W = (g == 0) ? NARROW_W : DATA_W;

        logic [W-1:0] la;
        logic [W-1:0] lb;
        logic [W:0]   diff;
        logic [W-1:0] res;
        flags_t       f;

        assign la   = opnd_a[W-1:0];
        assign lb   = imm_sext ? {{(W-IMM_W){opnd_b[IMM_W-1]}}, opnd_b[IMM_W-1:0]}
                               : opnd_b[W-1:0];
        assign diff = {1'b0, la} - {1'b0, lb};
        assign res  = is_test ? (la & lb) : diff[W-1:0];

        always_comb begin
            f.zf = (res == '0);
            f.sf = res[W-1];
            f.pf = even_ones(res[PARITY_W-1:0]);
            if (is_test) begin
                f.cf = 1'b0;
                f.of = 1'b0;
            end else begin
                f.cf = diff[W];
                f.of = (la[W-1] ^ lb[W-1]) & (res[W-1] ^ la[W-1]);
            end
        end
    end

    assign flags_o = wide ? g_lane[1].f : g_lane[0].f;

endmodule

// File: rtl/loop_eval.sv
module loop_eval
    import flagcond_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] cnt_in,
    input  logic [1:0]       kind,
    input  flags_t           flags,
    output logic [CNT_W-1:0] cnt_next,
    output logic             take
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    assign cnt_next = cnt_in - ONE;
    assign take     = (cnt_next != '0) && loop_gate(flags, loop_e'(kind));

endmodule

// File: rtl/branch_eval.sv
module branch_eval
    import flagcond_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [1:0]       op_sel,
    input  logic [3:0]       cond,
    input  flags_t           flags,
    input  logic [CNT_W-1:0] cnt_in,
    output logic [CNT_W-1:0] cnt_next,
    output logic             take
);

    logic loop_take;
    op_e  op;

    assign op = op_e'(op_sel);

    loop_eval #(.CNT_W(CNT_W)) i_loop (
        .cnt_in   (cnt_in),
        .kind     (cond[1:0]),
        .flags    (flags),
        .cnt_next (cnt_next),
        .take     (loop_take)
    );

    always_comb begin
        case (op)
            OP_BRANCH: take = cond_holds(flags, cc_e'(cond));
            OP_LOOP:   take = loop_take;
            default:   take = 1'b0;
        endcase
    end

    always_comb begin
        if (op == OP_BRANCH && cc_e'(cond) == CC_NEVER)
            assert_never_code_R9: assert (!take);
    end

endmodule

// File: rtl/flagcond_top.sv
module flagcond_top
    import flagcond_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int NARROW_W = 16,
    parameter int IMM_W    = 8,
    parameter int CNT_W    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [1:0]        op_sel,
    input  logic              wide,
    input  logic              imm_sext,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [3:0]        cond,
    input  logic [CNT_W-1:0]  cnt_in,
    output logic              done_o,
    output logic              take_o,
    output logic              zf_o,
    output logic              sf_o,
    output logic              cf_o,
    output logic              of_o,
    output logic              pf_o,
    output logic [CNT_W-1:0]  cnt_o
);

    op_e              op;
    flags_t           flags_c;
    flags_t           flags_q;
    logic [CNT_W-1:0] cnt_c;
    logic [CNT_W-1:0] cnt_q;
    logic             take_c;
    logic             take_q;
    logic             done_q;
    logic             sets_flags;

    assign op         = op_e'(op_sel);
    assign sets_flags = (op == OP_CMP) || (op == OP_TEST);

    flag_gen #(
        .DATA_W   (DATA_W),
        .NARROW_W (NARROW_W),
        .IMM_W    (IMM_W)
    ) i_flags (
        .is_test  (op == OP_TEST),
        .wide     (wide),
        .imm_sext (imm_sext),
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .flags_o  (flags_c)
    );

    branch_eval #(.CNT_W(CNT_W)) i_branch (
        .op_sel   (op_sel),
        .cond     (cond),
        .flags    (flags_q),
        .cnt_in   (cnt_in),
        .cnt_next (cnt_c),
        .take     (take_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            cnt_q   <= '0;
            take_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= in_valid;
            take_q <= in_valid && take_c;
            if (in_valid && sets_flags)
                flags_q <= flags_c;
            if (in_valid && op == OP_LOOP)
                cnt_q <= cnt_c;
        end
    end

    assign done_o = done_q;
    assign take_o = take_q;
    assign zf_o   = flags_q.zf;
    assign sf_o   = flags_q.sf;
    assign cf_o   = flags_q.cf;
    assign of_o   = flags_q.of;
    assign pf_o   = flags_q.pf;
    assign cnt_o  = cnt_q;

    assert_test_clears_cf_of_R5: assert property (@(posedge clk) disable iff (rst)
        in_valid && op_sel == 2'd1 |=> !cf_o && !of_o);

    assert_flags_hold_R11: assert property (@(posedge clk) disable iff (rst)
        in_valid && op_sel[1] |=> $stable({zf_o, sf_o, cf_o, of_o, pf_o}));

    assert_loop_exit_R10: assert property (@(posedge clk) disable iff (rst)
        in_valid && op_sel == 2'd3 && cnt_in == CNT_W'(1) |=> !take_o && cnt_o == '0);

    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !done_o && !take_o);

    assert_equal_cmp_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid && op_sel == 2'd0 && wide && !imm_sext && opnd_a == opnd_b
        |=> zf_o && !cf_o && !of_o);

endmodule

// File: tb/test_flagcond_top.sv
module test_flagcond_top;

    localparam int DATA_W   = 32;
    localparam int NARROW_W = 16;
    localparam int IMM_W    = 8;
    localparam int CNT_W    = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [1:0]        op_sel = '0;
    logic              wide = 1'b0;
    logic              imm_sext = 1'b0;
    logic [DATA_W-1:0] opnd_a = '0;
    logic [DATA_W-1:0] opnd_b = '0;
    logic [3:0]        cond = '0;
    logic [CNT_W-1:0]  cnt_in = '0;
    logic              done_o, take_o, zf_o, sf_o, cf_o, of_o, pf_o;
    logic [CNT_W-1:0]  cnt_o;

    always #2.5 clk = ~clk;

    flagcond_top #(
        .DATA_W(DATA_W), .NARROW_W(NARROW_W), .IMM_W(IMM_W), .CNT_W(CNT_W)
    ) i_flagcond_top (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel), .wide(wide),
        .imm_sext(imm_sext), .opnd_a(opnd_a), .opnd_b(opnd_b), .cond(cond),
        .cnt_in(cnt_in), .done_o(done_o), .take_o(take_o), .zf_o(zf_o),
        .sf_o(sf_o), .cf_o(cf_o), .of_o(of_o), .pf_o(pf_o), .cnt_o(cnt_o)
    );

    typedef struct {
        logic [4:0]       fl;    // zf sf cf of pf
        logic             take;
        logic [CNT_W-1:0] cnt;
        string            tag;
    } exp_t;

    exp_t        sb[$];
    int          n_checks = 0;
    int          n_fail   = 0;
    logic [4:0]  m_fl  = '0;
    logic [CNT_W-1:0] m_cnt = '0;
    bit          finished = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Reference flags, worked from the requirement text
    function automatic logic [4:0] ref_flags(input bit is_test, input bit w32, input bit imm,
                                             input logic [31:0] a, input logic [31:0] b);
        logic [31:0] mask, am, bm, r;
        int          top;
        logic        zf, sf, cf, ofl, pf;
        mask = w32 ? 32'hFFFF_FFFF : 32'h0000_FFFF;
        top  = w32 ? 31 : 15;
        am   = a & mask;
        bm   = (imm ? {{24{b[7]}}, b[7:0]} : b) & mask;
        r    = is_test ? (am & bm) : ((am - bm) & mask);
        zf   = (r == 0);
        sf   = r[top];
        cf   = is_test ? 1'b0 : (am < bm);
        ofl  = is_test ? 1'b0 : ((am[top] != bm[top]) && (r[top] != am[top]));
        pf   = ($countones(r[7:0]) % 2) == 0;
        return {zf, sf, cf, ofl, pf};
    endfunction

    function automatic bit ref_branch(input logic [4:0] f, input int cc);
        bit z, s, c, o;
        z = f[4]; s = f[3]; c = f[2]; o = f[1];
        case (cc)
            0: return 1;  1: return z;  2: return !z;
            3: return !z && (s == o);  4: return s == o;  5: return s != o;
            6: return z || (s != o);   7: return !c && !z; 8: return !c;
            9: return c;  10: return c || z;  11: return o;  12: return !o;
            13: return s; 14: return !s; default: return 0;
        endcase
    endfunction

    task automatic issue(input int op, input bit w32, input bit imm, input logic [31:0] a,
                         input logic [31:0] b, input int cc, input logic [CNT_W-1:0] cnt,
                         input string tag);
        exp_t e;
        bit   t;
        @(negedge clk);
        in_valid = 1; op_sel = 2'(op); wide = w32; imm_sext = imm;
        opnd_a = a; opnd_b = b; cond = 4'(cc); cnt_in = cnt;
        t = 0;
        if (op == 0 || op == 1) m_fl = ref_flags(op == 1, w32, imm, a, b);
        else if (op == 2) t = ref_branch(m_fl, cc);
        else begin
            m_cnt = cnt - 1'b1;
            t = (m_cnt != 0) && ((cc % 4 == 1) ? m_fl[4] : (cc % 4 == 2) ? !m_fl[4] : 1'b1);
        end
        e.fl = m_fl; e.take = t; e.cnt = m_cnt; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 0;
        end
    endtask

    // Monitor: compares every completed result with the scoreboard head
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (done_o) begin
                if (sb.size() == 0) begin
                    check(0, "R12", "unexpected done_o", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check({zf_o, sf_o, cf_o, of_o, pf_o} == e.fl, e.tag, "flags zsco p",
                          {zf_o, sf_o, cf_o, of_o, pf_o}, e.fl);
                    check(take_o == e.take, e.tag, "take_o", take_o, e.take);
                    check(cnt_o == e.cnt, e.tag, "cnt_o", cnt_o, e.cnt);
                end
            end else begin
                check(take_o == 0, "R12", "take_o while idle", take_o, 0);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        check({done_o, take_o, zf_o, sf_o, cf_o, of_o, pf_o} == 0, "R1", "outputs after reset",
              {done_o, take_o, zf_o, sf_o, cf_o, of_o, pf_o}, 0);
        check(cnt_o == 0, "R1", "cnt_o after reset", cnt_o, 0);

        // R2 / R7 / R8: equal operands
        issue(0, 1, 0, 32'd5, 32'd5, 0, 0, "R2 cmp equal");
        issue(2, 1, 0, 0, 0, 1, 0, "R7 eq taken");
        issue(2, 1, 0, 0, 0, 2, 0, "R7 ne not taken");
        issue(2, 1, 0, 0, 0, 3, 0, "R7 sgt not taken");
        issue(2, 1, 0, 0, 0, 4, 0, "R7 sge taken");
        issue(2, 1, 0, 0, 0, 6, 0, "R7 sle taken");
        issue(2, 1, 0, 0, 0, 10, 0, "R8 ule taken");
        issue(2, 1, 0, 0, 0, 7, 0, "R8 ugt not taken");
        // 1 - 2: borrow and negative
        issue(0, 1, 0, 32'd1, 32'd2, 0, 0, "R2 cmp borrow");
        issue(2, 1, 0, 0, 0, 5, 0, "R7 slt taken");
        issue(2, 1, 0, 0, 0, 9, 0, "R8 ult taken");
        issue(2, 1, 0, 0, 0, 8, 0, "R8 uge not taken");
        issue(2, 1, 0, 0, 0, 13, 0, "R9 neg taken");
        issue(2, 1, 0, 0, 0, 14, 0, "R9 pos not taken");
        // narrow overflow, upper bits differ and must be ignored
        issue(0, 0, 0, 32'hABCD_8000, 32'h1234_0001, 0, 0, "R3 narrow overflow");
        issue(2, 0, 0, 0, 0, 11, 0, "R9 ov taken");
        issue(2, 0, 0, 0, 0, 12, 0, "R9 nov not taken");
        issue(2, 0, 0, 0, 0, 5, 0, "R7 slt via overflow");
        issue(2, 0, 0, 0, 0, 7, 0, "R8 ugt taken");
        issue(0, 0, 0, 32'h0000_1234, 32'hFFFF_1234, 0, 0, "R2 narrow ignores upper");
        // wide positive minus negative overflows
        issue(0, 1, 0, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 0, 0, "R3 wide overflow");
        issue(2, 1, 0, 0, 0, 3, 0, "R7 sgt taken with overflow");
        issue(2, 1, 0, 0, 0, 9, 0, "R8 ult taken wide");
        // immediates
        issue(0, 1, 1, 32'hFFFF_FFFF, 32'h0000_00FF, 0, 0, "R4 imm -1 wide");
        issue(0, 0, 1, 32'h0000_FF80, 32'h0000_0080, 0, 0, "R4 imm -128 narrow");
        issue(0, 1, 1, 32'h0000_0010, 32'hFFFF_FF7F, 0, 0, "R4 imm positive");
        issue(1, 1, 1, 32'hFFFF_FFFF, 32'h0000_0080, 0, 0, "R4 test imm sign bits");
        // test operations and parity
        issue(0, 1, 0, 32'd0, 32'd1, 0, 0, "R2 set cf before test");
        issue(1, 1, 0, 32'h0000_00F0, 32'h0000_003C, 0, 0, "R5 test clears cf");
        issue(1, 1, 0, 32'h8000_0000, 32'h8000_0001, 0, 0, "R5 test sign");
        issue(1, 0, 0, 32'h0000_0055, 32'h0000_00AA, 0, 0, "R5 test zero");
        issue(1, 0, 0, 32'h0000_8007, 32'h0000_80FF, 0, 0, "R6 odd parity");
        issue(0, 1, 0, 32'h0000_0103, 32'h0000_0000, 0, 0, "R6 parity low byte only");
        issue(2, 1, 0, 0, 0, 0, 0, "R9 always taken");
        issue(2, 1, 0, 0, 0, 15, 0, "R9 never taken");
        // loops
        issue(3, 1, 0, 0, 0, 0, 16'd5, "R10 loop count 5");
        issue(3, 1, 0, 0, 0, 0, 16'd1, "R10 loop exit at one");
        issue(3, 1, 0, 0, 0, 3, 16'd0, "R10 loop wrap from zero");
        issue(0, 1, 0, 32'd9, 32'd9, 0, 0, "R2 set zf for loop");
        issue(3, 1, 0, 32'd1, 32'd2, 1, 16'd7, "R10 loop while equal taken");
        issue(3, 1, 0, 0, 0, 2, 16'd7, "R10 loop while not-equal stops");
        issue(0, 1, 0, 32'd9, 32'd3, 0, 0, "R2 clear zf for loop");
        issue(3, 1, 0, 0, 0, 1, 16'd7, "R10 loop while equal stops");
        issue(3, 1, 0, 0, 0, 2, 16'd3, "R10 loop while not-equal taken");
        issue(2, 1, 0, 32'h1, 32'h1, 5, 0, "R11 branch keeps flags");
        idle(2);
        issue(0, 0, 0, 32'h0000_0000, 32'h0000_0001, 0, 0, "R12 after idle");
        idle(3);
        check(sb.size() == 0, "R12", "results outstanding", sb.size(), 0);
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL R12 watchdog expired: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule